// File: doc/BRIEF.md
# Two-Thread Event-Driven Pipeline Arbiter

This block decides which of two hardware threads owns a shared in-order execution pipeline. Every cycle it takes event inputs from the memory hierarchy and the pipeline. These are a last-level demand miss by the running thread, a fill returning for the parked thread, a switch hint, a semaphore release, a long pipeline stall and a secondary miss to a line already under prefetch. Each event nudges a per-thread urgency score up or down. Most events only request a switch, and the request is honoured when the parked thread is at least as urgent as the running one after that cycle's adjustments. A hint, or expiry of the fairness timer, forces the switch.

A taken switch shows as a single-cycle pulse. The active-thread ID flips on the following clock edge. After every flip a minimum residency window blocks further switches, which stops the threads bouncing back and forth. The fairness timer and the stall-length threshold are run-time settings.

Top module: `soe_thread_arbiter`

## Requirements
- R1: With the synchronous active-low reset asserted, `active_tid` is 0 and `switch_pulse` is 0. Both urgency scores start at mid-scale (8 of 0..15). The fairness timer loads `cfg_timeout`, and the residency window is open.
- R2: `switch_pulse` is never high on two consecutive cycles. `active_tid` inverts on the edge right after a cycle with `switch_pulse` high, and holds on every other edge.
- R3: A last-level demand miss (`llc_miss`) lowers the running thread's urgency by 2. The score saturates at 0. The miss is a conditional switch request.
- R4: A fill return for the parked thread (`fill_parked`) raises the parked thread's urgency by 2. The score saturates at 15. It is a conditional switch request.
- R5: A semaphore release (`sem_release`) raises the parked thread's urgency by 1. An extended stall and a secondary miss after prefetch (`pf_sec_miss`) each lower the running thread's urgency by 1. Events in the same cycle add up, and each of these is a conditional switch request.
- R6: A conditional request is taken when, after the cycle's adjustments, the parked urgency is greater than or equal to the running urgency. Otherwise it is dropped. Urgency updates happen every cycle, blocked or not.
- R7: A hint (`switch_hint`) forces a switch whatever the urgency scores are.
- R8: The fairness timer reloads from `cfg_timeout` (up to 1023) on every flip of `active_tid`. It then counts down once per cycle. When it reaches 0 it forces a switch, and it stays at 0 until that switch is taken.
- R9: No switch pulse is raised while a pulse is already high, or within the residency window. The window starts at the flip and lasts max(`cfg_min_res`, 4) cycles. Conditional and hint events in that time are dropped, though their urgency effects remain. A pending timeout waits for the window to close.
- R10: A stall is extended on the N-th consecutive cycle that `stall_in` is high, where N is `cfg_stall_lim` (0 is treated as 1). The event fires once per run of stall cycles. A low cycle restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_timeout | input | 10 | Fairness timer reload value in cycles |
| cfg_min_res | input | 4 | Minimum residency after a flip (values below 4 act as 4) |
| cfg_stall_lim | input | 6 | Consecutive stall cycles that count as extended |
| llc_miss | input | 1 | Last-level demand miss by the running thread |
| fill_parked | input | 1 | Fill data returned for the parked thread |
| switch_hint | input | 1 | Explicit switch hint from the running thread |
| sem_release | input | 1 | Semaphore release |
| stall_in | input | 1 | Pipeline stalled this cycle |
| pf_sec_miss | input | 1 | Secondary miss to a line being prefetched |
| active_tid | output | 1 | Thread currently owning the pipeline |
| switch_pulse | output | 1 | One-cycle switch indication |

## Verification
The hardest case to reach is a conditional request that arrives on the very cycle the residency window closes, with the two urgency scores exactly equal. Whether the switch is taken then depends on both the window count and the `>=` tie rule. A second hard case is a timeout that expires inside the window and has to stay pending. Directed sequences drive urgencies to equality through miss and fill pairs and then place events at each offset around the end of the window. A long random phase follows, with sparse events and configurations changed while idle. A behavioural model checks the result on every cycle.

// File: rtl/soe_arb_pkg.sv
package soe_arb_pkg;
   localparam int NUM_THR = 2;

   function automatic int clamp_range(input int v, input int hi);
      if (v < 0)
         return 0;
      else if (v > hi)
         return hi;
      else
         return v;
   endfunction
endpackage

// File: rtl/soe_urgency_bank.sv
module soe_urgency_bank
   import soe_arb_pkg::*;
#(
   parameter int URG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_tid,
   input  logic [2:0]       act_dec,
   input  logic [1:0]       park_inc,
   output logic [URG_W-1:0] urg_act_new,
   output logic [URG_W-1:0] urg_park_new
);
   localparam int URG_MAX  = (1 << URG_W) - 1;
   localparam int URG_INIT = 1 << (URG_W - 1);

   if (URG_W < 2) begin : g_chk_w
      $error("soe_urgency_bank: URG_W must be at least 2");
   end

   logic [URG_W-1:0] urg_q [NUM_THR];
   logic [URG_W-1:0] cur_act, cur_park;

   always_comb begin
      cur_act      = urg_q[act_tid];
      cur_park     = urg_q[~act_tid];
      urg_act_new  = URG_W'(clamp_range(int'(cur_act) - int'(act_dec), URG_MAX));
      urg_park_new = URG_W'(clamp_range(int'(cur_park) + int'(park_inc), URG_MAX));
   end

   for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
      always_ff @(posedge clk) begin
         if (!rst_n)
            urg_q[g] <= URG_W'(URG_INIT);
         else if (act_tid == g[0])
            urg_q[g] <= urg_act_new;
         else
            urg_q[g] <= urg_park_new;
      end

      // Only a parked thread gains urgency, only a running one loses it.
      assert_park_only_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (urg_q[g] > $past(urg_q[g])) |-> ($past(act_tid) != g[0]));
      assert_active_only_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (urg_q[g] < $past(urg_q[g])) |-> ($past(act_tid) == g[0]));
   end
endmodule

// File: rtl/soe_stall_detect.sv
module soe_stall_detect #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stall_in,
   input  logic [CNT_W-1:0] lim,
   output logic             ext_stall
);
   if (CNT_W < 1) begin : g_chk_w
      $error("soe_stall_detect: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] lim_eff;

   always_comb begin
      lim_eff   = (lim == '0) ? CNT_W'(1) : lim;
      ext_stall = stall_in && (run_q == lim_eff - CNT_W'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_q <= '0;
      else if (!stall_in)
         run_q <= '0;
      else if (run_q < lim_eff)
         run_q <= run_q + CNT_W'(1);
   end

   assert_ext_needs_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ext_stall |-> stall_in);
   assert_ext_once_per_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ext_stall |=> !ext_stall);
endmodule

// File: rtl/soe_switch_timer.sv
module soe_switch_timer #(
   parameter int TMO_W   = 10,
   parameter int RES_W   = 4,
   parameter int RES_MIN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flip,
   input  logic [TMO_W-1:0] cfg_timeout,
   input  logic [RES_W-1:0] cfg_min_res,
   output logic             tmo_expired,
   output logic             res_busy
);
   if (RES_MIN < 1 || (1 << RES_W) <= RES_MIN) begin : g_chk_res
      $error("soe_switch_timer: RES_W cannot hold RES_MIN");
   end

   logic [TMO_W-1:0] tmo_q;
   logic [RES_W-1:0] res_q;
   logic [RES_W-1:0] res_eff;

   always_comb begin
      res_eff     = (cfg_min_res < RES_W'(RES_MIN)) ? RES_W'(RES_MIN) : cfg_min_res;
      tmo_expired = (tmo_q == '0);
      res_busy    = (res_q != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmo_q <= cfg_timeout;
         res_q <= '0;
      end else if (flip) begin
         tmo_q <= cfg_timeout;
         res_q <= res_eff - RES_W'(1);
      end else begin
         if (tmo_q != '0) tmo_q <= tmo_q - TMO_W'(1);
         if (res_q != '0) res_q <= res_q - RES_W'(1);
      end
   end

   assert_tmo_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flip |=> (tmo_q == $past(cfg_timeout)));
   assert_res_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flip |=> res_busy);
endmodule

// File: rtl/soe_thread_arbiter.sv
module soe_thread_arbiter #(
   parameter int URG_W   = 4,
   parameter int TMO_W   = 10,
   parameter int RES_W   = 4,
   parameter int STALL_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TMO_W-1:0]   cfg_timeout,
   input  logic [RES_W-1:0]   cfg_min_res,
   input  logic [STALL_W-1:0] cfg_stall_lim,
   input  logic               llc_miss,
   input  logic               fill_parked,
   input  logic               switch_hint,
   input  logic               sem_release,
   input  logic               stall_in,
   input  logic               pf_sec_miss,
   output logic               active_tid,
   output logic               switch_pulse
);
   logic             ext_stall, tmo_expired, res_busy;
   logic [2:0]       act_dec;
   logic [1:0]       park_inc;
   logic [URG_W-1:0] urg_act_new, urg_park_new;
   logic             cond_req, blocked, take;
   logic             tid_q, pulse_q;

   soe_stall_detect #(.CNT_W(STALL_W)) u_stall (
      .clk       (clk),
      .rst_n     (rst_n),
      .stall_in  (stall_in),
      .lim       (cfg_stall_lim),
      .ext_stall (ext_stall)
   );

   soe_urgency_bank #(.URG_W(URG_W)) u_urg (
      .clk          (clk),
      .rst_n        (rst_n),
      .act_tid      (tid_q),
      .act_dec      (act_dec),
      .park_inc     (park_inc),
      .urg_act_new  (urg_act_new),
      .urg_park_new (urg_park_new)
   );

   soe_switch_timer #(.TMO_W(TMO_W), .RES_W(RES_W), .RES_MIN(4)) u_tmr (
      .clk         (clk),
      .rst_n       (rst_n),
      .flip        (pulse_q),
      .cfg_timeout (cfg_timeout),
      .cfg_min_res (cfg_min_res),
      .tmo_expired (tmo_expired),
      .res_busy    (res_busy)
   );

   always_comb begin
      act_dec  = {llc_miss, 1'b0} + {2'b00, ext_stall} + {2'b00, pf_sec_miss};
      park_inc = {fill_parked, 1'b0} + {1'b0, sem_release};
      cond_req = llc_miss | fill_parked | sem_release | ext_stall | pf_sec_miss;
      blocked  = pulse_q | res_busy;
      take     = !blocked &&
                 (switch_hint || tmo_expired || (cond_req && (urg_park_new >= urg_act_new)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tid_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= take;
         if (pulse_q) tid_q <= ~tid_q;
      end
   end

   assign active_tid   = tid_q;
   assign switch_pulse = pulse_q;

   assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      switch_pulse |=> !switch_pulse);
   assert_tid_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
      switch_pulse |=> (active_tid != $past(active_tid)));
   assert_tid_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !switch_pulse |=> $stable(active_tid));
   assert_no_switch_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_busy |=> !switch_pulse);
   assert_hint_forces_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (switch_hint && !res_busy && !switch_pulse) |=> switch_pulse);
   assert_timeout_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_expired && !res_busy && !switch_pulse) |=> switch_pulse);
endmodule

// File: tb/soe_thread_arbiter_tb.sv
module soe_thread_arbiter_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] cfg_timeout = 10'd1000;
   logic [3:0] cfg_min_res = 4'd4;
   logic [5:0] cfg_stall_lim = 6'd32;
   logic       llc_miss = 0, fill_parked = 0, switch_hint = 0;
   logic       sem_release = 0, stall_in = 0, pf_sec_miss = 0;
   logic       active_tid, switch_pulse;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string phase = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   soe_thread_arbiter u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_timeout(cfg_timeout), .cfg_min_res(cfg_min_res), .cfg_stall_lim(cfg_stall_lim),
      .llc_miss(llc_miss), .fill_parked(fill_parked), .switch_hint(switch_hint),
      .sem_release(sem_release), .stall_in(stall_in), .pf_sec_miss(pf_sec_miss),
      .active_tid(active_tid), .switch_pulse(switch_pulse)
   );

   // Behavioural reference model
   int m_urg [2];
   int m_tid, m_pulse, m_res, m_tmo, m_run;

   always @(posedge clk) begin
      int a, p, ua, up, lim, rmin;
      bit ext, cond, blk, tk;
      if (!rst_n) begin
         m_urg[0] = 8; m_urg[1] = 8;
         m_tid = 0; m_pulse = 0; m_res = 0; m_run = 0;
         m_tmo = int'(cfg_timeout);
      end else begin
         a    = m_tid; p = 1 - m_tid;
         lim  = (cfg_stall_lim == 0) ? 1 : int'(cfg_stall_lim);
         rmin = (cfg_min_res < 4) ? 4 : int'(cfg_min_res);
         ext  = stall_in && (m_run == lim - 1);
         ua   = m_urg[a] - 2*int'(llc_miss) - int'(ext) - int'(pf_sec_miss);
         up   = m_urg[p] + 2*int'(fill_parked) + int'(sem_release);
         if (ua < 0) ua = 0;
         if (up > 15) up = 15;
         cond = llc_miss | fill_parked | sem_release | ext | pf_sec_miss;
         blk  = (m_pulse != 0) || (m_res != 0);
         tk   = !blk && (switch_hint || m_tmo == 0 || (cond && up >= ua));
         m_urg[a] = ua; m_urg[p] = up;
         if (!stall_in) m_run = 0;
         else if (m_run < lim) m_run = m_run + 1;
         if (m_pulse != 0) begin
            m_tid = p; m_res = rmin - 1; m_tmo = int'(cfg_timeout);
         end else begin
            if (m_res > 0) m_res = m_res - 1;
            if (m_tmo > 0) m_tmo = m_tmo - 1;
         end
         m_pulse = tk ? 1 : 0;
      end
   end

   // Compare on every clock, away from the edge
   always @(posedge clk) begin
      #2;
      if (!done) begin
         checks++;
         if (int'(active_tid) != m_tid || int'(switch_pulse) != m_pulse) begin
            errors++;
            $display("FAIL %s: tid/pulse actual %0d/%0d expected %0d/%0d at %0t",
                     phase, active_tid, switch_pulse, m_tid, m_pulse, $time);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ev(input bit m, input bit f, input bit h, input bit s, input bit p, input int gap);
      @(negedge clk);
      llc_miss = m; fill_parked = f; switch_hint = h; sem_release = s; pf_sec_miss = p;
      @(negedge clk);
      llc_miss = 0; fill_parked = 0; switch_hint = 0; sem_release = 0; pf_sec_miss = 0;
      idle(gap);
   endtask

   task automatic chk(input string req, input bit cond, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      phase = "R1";
      idle(4);
      chk("R1", active_tid == 0, active_tid, 0);
      chk("R1", switch_pulse == 0, switch_pulse, 0);
      rst_n = 1;
      idle(3);
      chk("R1", active_tid == 0 && switch_pulse == 0, active_tid, 0);

      // R3: miss lowers running urgency 8->6, parked 8 >= 6, switch taken
      phase = "R3";
      ev(1,0,0,0,0, 0);
      chk("R3", switch_pulse == 1, switch_pulse, 1);
      @(negedge clk);
      chk("R2", active_tid == 1 && switch_pulse == 0, active_tid, 1);
      idle(8);
      // repeated misses drive urgency toward saturation at 0
      repeat (6) ev(1,0,0,0,0, 6);

      // R4 / R6: fill for parked thread
      phase = "R4";
      repeat (6) ev(0,1,0,0,0, 6);
      phase = "R6";
      ev(1,1,0,0,0, 6);
      ev(0,0,0,1,0, 6);
      ev(0,0,0,0,1, 6);

      // R5: combined events in one cycle
      phase = "R5";
      ev(1,0,0,1,1, 6);
      ev(0,1,0,1,0, 6);
      ev(0,0,0,1,0, 1);
      ev(0,0,0,0,1, 1);

      // R7: hint forces regardless of urgency
      phase = "R7";
      repeat (4) ev(0,0,1,0,0, 5);
      chk("R7", switch_pulse == 0, switch_pulse, 0);

      // R9: events inside the residency window are dropped
      phase = "R9";
      cfg_min_res = 4'd2;
      ev(0,0,1,0,0, 0);
      ev(0,0,1,0,0, 0);
      ev(0,0,1,0,0, 0);
      idle(10);
      cfg_min_res = 4'd9;
      for (int k = 0; k < 12; k++) begin
         ev(0,0,1,0,0, k);
         ev(0,1,0,0,0, k);
      end
      cfg_min_res = 4'd4;
      idle(10);

      // R8: short fairness timeout, including expiry inside the window
      phase = "R8";
      cfg_timeout = 10'd15;
      idle(80);
      cfg_timeout = 10'd2;
      idle(30);
      cfg_timeout = 10'd0;
      idle(20);
      cfg_timeout = 10'd1000;
      ev(0,0,1,0,0, 10);

      // R10: extended stall detection
      phase = "R10";
      cfg_stall_lim = 6'd5;
      @(negedge clk); stall_in = 1; idle(20); stall_in = 0; idle(6);
      @(negedge clk); stall_in = 1; idle(3); stall_in = 0; idle(6);
      cfg_stall_lim = 6'd0;
      @(negedge clk); stall_in = 1; idle(4); stall_in = 0; idle(6);
      cfg_stall_lim = 6'd32;
      @(negedge clk); stall_in = 1; idle(40); stall_in = 0; idle(6);

      // Random phase
      phase = "R6";
      for (int r = 0; r < 4000; r++) begin
         @(negedge clk);
         if (($urandom % 200) == 0 && !stall_in) begin
            cfg_timeout   = 10'($urandom % 64);
            cfg_min_res   = 4'($urandom % 16);
            cfg_stall_lim = 6'($urandom % 8);
         end
         llc_miss    = (($urandom % 12) == 0);
         fill_parked = (($urandom % 12) == 0);
         switch_hint = (($urandom % 40) == 0);
         sem_release = (($urandom % 16) == 0);
         pf_sec_miss = (($urandom % 16) == 0);
         if (($urandom % 8) == 0) stall_in = ~stall_in;
      end
      @(negedge clk);
      llc_miss = 0; fill_parked = 0; switch_hint = 0;
      sem_release = 0; pf_sec_miss = 0; stall_in = 0;
      idle(10);

      // R1 again: reset mid-run returns to thread 0
      phase = "R1";
      rst_n = 0;
      idle(3);
      chk("R1", active_tid == 0 && switch_pulse == 0, active_tid, 0);
      rst_n = 1;
      idle(5);
      finish_run();
   end
endmodule